// File: doc/BRIEF.md
# Paged Program Counter with Circular Return Stack

This block produces the 13-bit instruction address of a small processor whose program space is 8K words. It holds the counter itself, a 5-bit holding latch that supplies the upper address bits, and an 8-level return stack of 13-bit entries. The control logic around it raises single-cycle command pulses to step, overwrite, branch, call, return or enter an interrupt. The block answers with the current address, its low byte, and a fetch address folded into the memory actually implemented.

The upper five counter bits can only be set through the holding latch. A low-byte write takes all five latch bits. A jump or call takes only the top two, because the instruction carries eleven address bits. The return stack is a ring: it never reports overflow or underflow. Its pointer is hidden, so deep nesting silently overwrites the oldest return addresses.

All commands are plain level pulses sampled on the rising clock edge. There is no data stream here and no back-pressure: every command is accepted in the cycle it is presented.

Top module: `pcu_top`

## Requirements
- R1: While `rst_n` is low, the counter, the holding latch, the stack pointer and all eight stack entries are cleared. After reset the address is 0x0000.
- R2: When several commands arrive in one cycle, only one acts, in this priority from highest to lowest: `irq`, `ret`, `call`, `jump`, `lo_wr`, `advance`. A cycle with none of these leaves the counter unchanged.
- R3: `advance` adds one to the 13-bit counter. 0x1FFF steps to 0x0000.
- R4: `lo_wr` loads the counter with the latch in bits 12:8 and `lo_wdata` in bits 7:0. It uses the latch value held before any latch write in the same cycle.
- R5: `jump` loads bits 10:0 from `jump_target` and bits 12:11 from latch bits 4:3. The stack is not touched.
- R6: `call` pushes the current address plus one, then loads the counter exactly as a jump does.
- R7: `irq` pushes the current address plus one and loads 0x0004.
- R8: `ret` loads the counter with the full 13-bit entry most recently pushed.
- R9: The stack is an 8-entry ring. A ninth push overwrites the first entry, a tenth push the second, and so on. A pop on an empty ring still steps the pointer back modulo 8 and returns whatever entry sits there. No status of any kind is produced.
- R10: `hi_wr` loads the latch from `hi_wdata` and does not change the counter. Pushes and pops never alter the latch, so its value is still seen by the next low-byte write.
- R11: `pc_lo` equals counter bits 7:0. `fetch_addr` equals the counter modulo 2^IMPL_W (4096 by default), with its upper bits zero, so addresses beyond the implemented memory wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| advance | input | 1 | Step the counter by one |
| lo_wr | input | 1 | Write the low byte (upper bits from latch) |
| lo_wdata | input | 8 | Data for a low-byte write |
| hi_wr | input | 1 | Load the holding latch |
| hi_wdata | input | 5 | Data for the holding latch |
| jump | input | 1 | Branch to `jump_target` |
| call | input | 1 | Push return address and branch |
| jump_target | input | 11 | Branch target from the instruction |
| ret | input | 1 | Pop the return stack into the counter |
| irq | input | 1 | Push return address and go to the interrupt vector |
| pc_out | output | 13 | Current program address |
| pc_lo | output | 8 | Readable low byte of the address |
| fetch_addr | output | 13 | Address folded into the implemented memory |

## Verification
Every result here comes from one register stage. A command sampled at a rising edge shows on `pc_out`, `pc_lo` and `fetch_addr` right after that edge, and a latch write is seen by the first low-byte write or jump that follows it. The bench drives each command just after a falling edge. At the same rising edge it advances a behavioural model with the same inputs, and it compares all three outputs at the next falling edge. This puts every comparison half a cycle after the edge that produced the result. Directed sequences cover carry wrap, ring overwrite and empty-ring pops; a long weighted random run covers command collisions.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  typedef enum logic [2:0] {
    OP_HOLD,
    OP_STEP,
    OP_LOWR,
    OP_JUMP,
    OP_CALL,
    OP_RET,
    OP_IRQ
  } pc_op_e;

  // Fixed priority: interrupt entry beats return beats call beats jump
  // beats low-byte write beats step.
  function automatic pc_op_e pick_op(input logic irq, input logic ret,
                                     input logic call, input logic jump,
                                     input logic lo_wr, input logic adv);
    if (irq)        return OP_IRQ;
    else if (ret)   return OP_RET;
    else if (call)  return OP_CALL;
    else if (jump)  return OP_JUMP;
    else if (lo_wr) return OP_LOWR;
    else if (adv)   return OP_STEP;
    else            return OP_HOLD;
  endfunction

endpackage

// File: rtl/pcu_next.sv
module pcu_next
  import pcu_pkg::*;
#(
  parameter int PC_W     = 13,
  parameter int LO_W     = 8,
  parameter int TGT_W    = 11,
  parameter int IRQ_ADDR = 4
) (
  input  pc_op_e                op,
  input  logic [PC_W-1:0]       pc_q,
  input  logic [PC_W-LO_W-1:0]  hi_q,
  input  logic [LO_W-1:0]       lo_data,
  input  logic [TGT_W-1:0]      target,
  input  logic [PC_W-1:0]       pop_data,
  output logic [PC_W-1:0]       pc_d,
  output logic                  push_en,
  output logic                  pop_en,
  output logic [PC_W-1:0]       push_data
);
  localparam int HI_W = PC_W - LO_W;
  localparam int JK   = PC_W - TGT_W;
  localparam logic [PC_W-1:0] IRQ_VEC = PC_W'(IRQ_ADDR);

  logic [PC_W-1:0] pc_inc;
  logic [PC_W-1:0] branch_pc;

  assign pc_inc    = pc_q + 1'b1;
  assign branch_pc = {hi_q[HI_W-1 -: JK], target};
  assign push_data = pc_inc;
  assign push_en   = (op == OP_CALL) || (op == OP_IRQ);
  assign pop_en    = (op == OP_RET);

  always_comb begin
    unique case (op)
      OP_STEP: pc_d = pc_inc;
      OP_LOWR: pc_d = {hi_q, lo_data};
      OP_JUMP,
      OP_CALL: pc_d = branch_pc;
      OP_RET:  pc_d = pop_data;
      OP_IRQ:  pc_d = IRQ_VEC;
      default: pc_d = pc_q;
    endcase
  end
endmodule

// File: rtl/pcu_ring.sv
module pcu_ring #(
  parameter int W     = 13,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata
);
  // DEPTH must be a power of two so the pointer wraps by itself.
  localparam int PW = $clog2(DEPTH);

  logic [PW-1:0] sp;
  logic [PW-1:0] top_idx;
  logic [W-1:0]  slot [DEPTH];

  assign top_idx = sp - 1'b1;
  assign rdata   = slot[top_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sp <= '0;
    else if (push) sp <= sp + 1'b1;
    else if (pop)  sp <= top_idx;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       slot[i] <= '0;
      else if (push && sp == PW'(i))    slot[i] <= wdata;
    end
  end
endmodule

// File: rtl/pcu_top.sv
module pcu_top
  import pcu_pkg::*;
#(
  parameter int PC_W     = 13,
  parameter int LO_W     = 8,
  parameter int TGT_W    = 11,
  parameter int DEPTH    = 8,
  parameter int IMPL_W   = 12,
  parameter int IRQ_ADDR = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  advance,
  input  logic                  lo_wr,
  input  logic [LO_W-1:0]       lo_wdata,
  input  logic                  hi_wr,
  input  logic [PC_W-LO_W-1:0]  hi_wdata,
  input  logic                  jump,
  input  logic                  call,
  input  logic [TGT_W-1:0]      jump_target,
  input  logic                  ret,
  input  logic                  irq,
  output logic [PC_W-1:0]       pc_out,
  output logic [LO_W-1:0]       pc_lo,
  output logic [PC_W-1:0]       fetch_addr
);
  localparam int HI_W = PC_W - LO_W;

  pc_op_e          op;
  logic [PC_W-1:0] pc_q, pc_d, push_data, pop_data;
  logic [HI_W-1:0] hi_q;
  logic            push_en, pop_en;

  assign op = pick_op(irq, ret, call, jump, lo_wr, advance);

  pcu_next #(
    .PC_W(PC_W), .LO_W(LO_W), .TGT_W(TGT_W), .IRQ_ADDR(IRQ_ADDR)
  ) u_next (
    .op(op), .pc_q(pc_q), .hi_q(hi_q), .lo_data(lo_wdata),
    .target(jump_target), .pop_data(pop_data), .pc_d(pc_d),
    .push_en(push_en), .pop_en(pop_en), .push_data(push_data)
  );

  pcu_ring #(.W(PC_W), .DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n), .push(push_en), .pop(pop_en),
    .wdata(push_data), .rdata(pop_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_q <= '0;
    else if (hi_wr) hi_q <= hi_wdata;
  end

  assign pc_out = pc_q;
  assign pc_lo  = pc_q[LO_W-1:0];

  if (IMPL_W < PC_W) begin : g_fold
    assign fetch_addr = {{(PC_W-IMPL_W){1'b0}}, pc_q[IMPL_W-1:0]};
  end else begin : g_full
    assign fetch_addr = pc_q;
  end
endmodule

// File: rtl/pcu_chk.sv
module pcu_chk #(
  parameter int PC_W     = 13,
  parameter int LO_W     = 8,
  parameter int TGT_W    = 11,
  parameter int IRQ_ADDR = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 advance,
  input logic                 lo_wr,
  input logic [LO_W-1:0]      lo_wdata,
  input logic                 jump,
  input logic                 call,
  input logic [TGT_W-1:0]     jump_target,
  input logic                 ret,
  input logic                 irq,
  input logic [PC_W-1:0]      pc_out,
  input logic [PC_W-LO_W-1:0] hi_q
);
  localparam int HI_W = PC_W - LO_W;
  localparam int JK   = PC_W - TGT_W;

  logic any_cmd;
  assign any_cmd = irq | ret | call | jump | lo_wr | advance;

  // R1: first cycle out of reset starts at address zero
  a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> pc_out == '0);

  // R2: no command, no movement
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !any_cmd |=> $stable(pc_out));

  // R3: a lone step adds one modulo the counter width
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !irq && !ret && !call && !jump && !lo_wr)
      |=> pc_out == $past(pc_out) + 1'b1);

  // R4: low-byte write takes the whole latch
  a_r4_low_write: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_wr && !irq && !ret && !call && !jump)
      |=> pc_out == {$past(hi_q), $past(lo_wdata)});

  // R5 and R6: branches take only the top latch bits
  a_r5_branch: assert property (@(posedge clk) disable iff (!rst_n)
    ((jump || call) && !irq && !ret)
      |=> pc_out == {$past(hi_q[HI_W-1 -: JK]), $past(jump_target)});

  // R7: interrupt entry goes to the vector
  a_r7_vector: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> pc_out == PC_W'(IRQ_ADDR));
endmodule

bind pcu_top pcu_chk #(
  .PC_W(PC_W), .LO_W(LO_W), .TGT_W(TGT_W), .IRQ_ADDR(IRQ_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .advance(advance), .lo_wr(lo_wr),
  .lo_wdata(lo_wdata), .jump(jump), .call(call),
  .jump_target(jump_target), .ret(ret), .irq(irq),
  .pc_out(pc_out), .hi_q(hi_q)
);

// File: tb/sim_pcu_top.sv
`timescale 1ns/1ps
module sim_pcu_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        advance = 0, lo_wr = 0, hi_wr = 0, jump = 0, call = 0, ret = 0, irq = 0;
  logic [7:0]  lo_wdata = '0;
  logic [4:0]  hi_wdata = '0;
  logic [10:0] jump_target = '0;
  logic [12:0] pc_out, fetch_addr;
  logic [7:0]  pc_lo;

  always #2 clk = ~clk;

  pcu_top u0 (
    .clk(clk), .rst_n(rst_n), .advance(advance), .lo_wr(lo_wr),
    .lo_wdata(lo_wdata), .hi_wr(hi_wr), .hi_wdata(hi_wdata), .jump(jump),
    .call(call), .jump_target(jump_target), .ret(ret), .irq(irq),
    .pc_out(pc_out), .pc_lo(pc_lo), .fetch_addr(fetch_addr)
  );

  int    total = 0, bad = 0, cyc = 0;
  bit    done = 0;
  // behavioural reference
  int    m_pc = 0, m_hi = 0, m_sp = 0, m_live = 0;
  int    m_ring [8];
  string tag = "R1";

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_pc = 0; m_hi = 0; m_sp = 0; m_live = 0; tag = "R1";
      foreach (m_ring[k]) m_ring[k] = 0;
    end else begin
      int nxt;
      nxt = (m_pc + 1) % 8192;
      if (irq) begin
        tag = (m_live == 8) ? "R9" : "R7";
        m_ring[m_sp] = nxt; m_sp = (m_sp + 1) % 8;
        if (m_live < 8) m_live++;
        m_pc = 4;
      end else if (ret) begin
        tag = (m_live == 0) ? "R9" : "R8";
        m_sp = (m_sp + 7) % 8;
        if (m_live > 0) m_live--;
        m_pc = m_ring[m_sp];
      end else if (call) begin
        tag = (m_live == 8) ? "R9" : "R6";
        m_ring[m_sp] = nxt; m_sp = (m_sp + 1) % 8;
        if (m_live < 8) m_live++;
        m_pc = ((m_hi / 8) * 2048) + jump_target;
      end else if (jump) begin
        tag = "R5"; m_pc = ((m_hi / 8) * 2048) + jump_target;
      end else if (lo_wr) begin
        tag = "R4"; m_pc = m_hi * 256 + lo_wdata;
      end else if (advance) begin
        tag = "R3"; m_pc = nxt;
      end else begin
        tag = hi_wr ? "R10" : "R2";
      end
      if (hi_wr) m_hi = hi_wdata;
    end
  end

  always @(negedge clk) begin
    if (cyc > 0 && !done) begin
      total++;
      if (pc_out !== 13'(m_pc)) begin
        bad++;
        $display("FAIL %s pc_out actual=%h expected=%h", tag, pc_out, 13'(m_pc));
      end
      total++;
      if (pc_lo !== 8'(m_pc % 256)) begin
        bad++;
        $display("FAIL R11 pc_lo actual=%h expected=%h", pc_lo, 8'(m_pc % 256));
      end
      total++;
      if (fetch_addr !== 13'(m_pc % 4096)) begin
        bad++;
        $display("FAIL R11 fetch_addr actual=%h expected=%h", fetch_addr, 13'(m_pc % 4096));
      end
    end
  end

  task automatic drive(input bit a_irq, a_ret, a_call, a_jmp, a_lowr, a_adv, a_hiwr,
                       input logic [7:0] d, input logic [4:0] h, input logic [10:0] t);
    @(negedge clk); #1;
    irq = a_irq; ret = a_ret; call = a_call; jump = a_jmp; lo_wr = a_lowr;
    advance = a_adv; hi_wr = a_hiwr; lo_wdata = d; hi_wdata = h; jump_target = t;
  endtask

  task automatic idle();
    drive(0,0,0,0,0,0,0, 8'h00, 5'h00, 11'h000);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);          // R1: reset state compared each cycle
    #1 rst_n = 1'b1;
    idle(); idle();                      // R2: idle hold
    drive(0,0,0,0,0,0,1, 8'h00, 5'h1B, 11'h000);   // R10: latch only
    drive(0,0,0,0,1,0,0, 8'h34, 5'h00, 11'h000);   // R4 -> 0x1B34, R11 fold 0xB34
    drive(0,0,0,0,0,1,0, 8'h00, 5'h00, 11'h000);   // R3
    drive(0,0,0,1,0,0,0, 8'h00, 5'h00, 11'h123);   // R5 -> 0x1923
    drive(0,0,0,0,1,0,1, 8'h10, 5'h02, 11'h000);   // R4 uses old latch 0x1B
    drive(0,0,0,0,1,0,1, 8'hFF, 5'h1F, 11'h000);   // R4 with latch 0x02
    drive(0,0,0,0,1,0,0, 8'hFF, 5'h00, 11'h000);   // 0x1FFF
    drive(0,0,0,0,0,1,0, 8'h00, 5'h00, 11'h000);   // R3 wrap to 0
    for (int i = 0; i < 10; i++)                   // R6 and R9: ten calls
      drive(0,0,1,0,0,0,0, 8'h00, 5'h00, 11'(i * 37 + 5));
    for (int i = 0; i < 10; i++)                   // R8 and R9: ten returns
      drive(0,1,0,0,0,0,0, 8'h00, 5'h00, 11'h000);
    drive(1,0,0,0,0,0,0, 8'h00, 5'h00, 11'h000);   // R7
    drive(0,1,0,0,0,0,0, 8'h00, 5'h00, 11'h000);   // R8 back
    drive(1,1,1,1,1,1,1, 8'hAA, 5'h15, 11'h555);   // R2 priority: irq wins
    drive(0,1,1,1,1,1,0, 8'hAA, 5'h00, 11'h555);   // ret wins
    drive(0,0,1,1,1,1,0, 8'hAA, 5'h00, 11'h555);   // call wins
    drive(0,0,0,1,1,1,0, 8'hAA, 5'h00, 11'h0F0);   // jump wins
    drive(0,0,0,0,1,1,0, 8'h5A, 5'h00, 11'h000);   // low write wins
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      drive(r < 4, (r >= 4 && r < 16), (r >= 16 && r < 28), (r >= 28 && r < 36),
            (r >= 36 && r < 46), (r >= 46 && r < 90) || ($urandom_range(0,3) == 0),
            $urandom_range(0, 4) == 0,
            8'($urandom), 5'($urandom), 11'($urandom));
    end
    idle(); idle();
    finish_run();
  end

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end
endmodule